// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block is a first-in first-out buffer for 9-bit words that links two unrelated clock domains. A producer pushes words on its own write clock and a consumer pops them on its own read clock. Four active-low status flags report the fill state. The empty and almost-empty flags are owned by the read clock. The full and almost-full flags are owned by the write clock. Each domain sees the other's pointer through a Gray-coded two-stage synchronizer, so the empty and full flags are conservative and never let an access go through that the buffer cannot honour.

A single dual-purpose pin is captured while reset is active and sets the mode for the whole session:
- **Pin high:** the pin is a second, active-high write qualifier.
- **Pin low:** the pin is an active-low load strobe for two threshold registers that drive the almost flags.

The thresholds are set in one-word steps. Each threshold is written as two halves through a write-side walking pointer and can be read back through a separate read-side walking pointer. Both thresholds come out of reset at seven.

The output bus carries the last word popped, or the last threshold half read back. A separate drive-enable output follows the output-enable pin, so that the pad ring can place the bus in high impedance.

Top module: `xfifo_pflag`

## Requirements
- R1: Words pop in the order they were pushed. All 9 bits are unchanged, and they appear on `rd_data` at the first read-clock edge after the pop is accepted.
- R2: After reset the flags are `empty_n`=0, `almost_empty_n`=0, `full_n`=1 and `almost_full_n`=1, and `rd_data` is 0. Both thresholds are 7: read back in load mode, the four halves give 7, 0, 7, 0.
- R3: `dual_pin` is captured during reset, and its level then stays in force until the next reset. High selects dual-qualifier mode, in which the pin never loads or reads back a threshold. Low selects load mode.
- R4: A push happens on a write-clock edge only when `wr_en_n`=0, `dual_pin`=1 and `full_n`=1. With `dual_pin`=0 in dual-qualifier mode nothing is stored.
- R5: A pop happens on a read-clock edge only when `rd_en_a_n`=0, `rd_en_b_n`=0 and `empty_n`=1. If either enable is high, nothing is popped and `rd_data` holds its value.
- R6: The buffer holds exactly DEPTH words (64 by default). Once `full_n` is 0, further pushes are dropped and do not disturb stored data.
- R7: `almost_empty_n` is 0 while the stored count is less than or equal to the empty threshold. `almost_full_n` is 0 while the free space (DEPTH minus count) is less than or equal to the full threshold.
- R8: In load mode, a write-clock edge with `wr_en_n`=0 and `dual_pin`=0 stores `wr_data[3:0]` into the next threshold half instead of the buffer. The halves are taken in the order empty-threshold bits 3:0, empty-threshold bits 7:4, full-threshold bits 3:0, full-threshold bits 7:4, and the order wraps to the first half after the fourth. The half width is half of 2·ceil((log2(DEPTH)+1)/2), which is 4 bits for the default depth.
- R9: In load mode, a read-clock edge with `dual_pin`=0 and both read enables low places the next threshold half, zero-extended, on `rd_data`. It uses the same four-half order from its own pointer, which also wraps. The buffer is not popped.
- R10: `empty_n` goes high no later than four read-clock cycles after a push into an empty buffer completes.
- R11: `rd_data_drive` equals the inverse of `out_en_n` at all times.
- R12: Under arbitrary interleaving of the two clocks, each crossing pointer changes at most one bit per edge. The count seen by either side stays between 0 and DEPTH, so the buffer never overflows or underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| dual_pin | input | 1 | Mode select at reset; afterwards second write qualifier or threshold load strobe |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | 9 | Word to push, or threshold half in its low bits |
| rd_en_a_n | input | 1 | First active-low read enable |
| rd_en_b_n | input | 1 | Second active-low read enable |
| out_en_n | input | 1 | Active-low output enable |
| rd_data | output | 9 | Popped word or threshold half |
| rd_data_drive | output | 1 | High when the pad should drive `rd_data` |
| empty_n | output | 1 | Low when the buffer is empty (read domain) |
| almost_empty_n | output | 1 | Low at or below the empty threshold (read domain) |
| full_n | output | 1 | Low when the buffer is full (write domain) |
| almost_full_n | output | 1 | Low at or below the full threshold of free space (write domain) |

## Verification
The in-RTL properties check on every cycle the things a single clock can see:
- the Gray pointers move by at most one bit per edge;
- neither side's count goes outside 0 to DEPTH;
- no push is accepted when the write side's count is already DEPTH, and no pop when the read side's count is zero;
- the captured mode never changes outside reset.

The thresholds, the exact flag levels at chosen fill points, the walking order and wrap of the load and read-back pointers, data order through the crossing, the flag latency and the drive-enable mapping are all shown only by the bench's directed scenarios and its randomized two-clock traffic.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

  typedef enum logic {
    MODE_DUAL_WE   = 1'b0,
    MODE_PROG_FLAG = 1'b1
  } fifo_mode_e;

  // Walking order of the threshold halves; the order is behaviour.
  typedef enum logic [1:0] {
    HALF_AE_LO = 2'd0,
    HALF_AE_HI = 2'd1,
    HALF_AF_LO = 2'd2,
    HALF_AF_HI = 2'd3
  } ofs_half_e;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    for (int i = 0; i < 32; i++) b[i] = ^(g >> i);
    return b;
  endfunction

endpackage

// File: rtl/xfifo_rst_sync.sv
module xfifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         srst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, hold_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/xfifo_ram.sv
module xfifo_ram #(
  parameter int unsigned DW = 9,
  parameter int unsigned AW = 6,
  localparam int unsigned WORDS = 1 << AW
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/xfifo_wr_ctl.sv
module xfifo_wr_ctl
  import xfifo_pkg::*;
#(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned OFS_W   = 8,
  parameter int unsigned DEF_OFS = 7,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1,
  localparam int unsigned HW = OFS_W / 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             srst_n,
  input  logic             dual_pin,
  input  logic             wr_en_n,
  input  logic [HW-1:0]    ofs_din,
  input  logic [PW-1:0]    rgray_s,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic [PW-1:0]    wgray,
  output logic             full_n,
  output logic             afull_n,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs
);
  localparam logic [OFS_W-1:0] DEF_VAL = OFS_W'(DEF_OFS);

  fifo_mode_e   mode_q;
  ofs_half_e    lptr_q;
  logic [HW-1:0] half_q [4];
  logic [PW-1:0] wbin_q, wbin_d, wgray_q, rbin_s, fill_d, free_d;
  logic          full_n_d, afull_n_d, ld_fire, wr_fire;

  // mode capture while the synchronized reset is still low
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      mode_q <= MODE_DUAL_WE;
    else if (!srst_n) mode_q <= dual_pin ? MODE_DUAL_WE : MODE_PROG_FLAG;
  end

  always_comb begin
    ld_fire   = (mode_q == MODE_PROG_FLAG) && !wr_en_n && !dual_pin;
    wr_fire   = !wr_en_n && dual_pin && full_n;
    wbin_d    = wbin_q + PW'(wr_fire);
    rbin_s    = PW'(gray2bin(32'(rgray_s)));
    fill_d    = wbin_d - rbin_s;
    free_d    = PW'(DEPTH) - fill_d;
    full_n_d  = (fill_d != PW'(DEPTH));
    afull_n_d = (OFS_W'(free_d) > af_ofs);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
    end else begin
      if (wr_fire) begin
        wbin_q  <= wbin_d;
        wgray_q <= PW'(bin2gray(32'(wbin_d)));
      end
      full_n  <= full_n_d;
      afull_n <= afull_n_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      lptr_q             <= HALF_AE_LO;
      half_q[HALF_AE_LO] <= DEF_VAL[HW-1:0];
      half_q[HALF_AE_HI] <= DEF_VAL[OFS_W-1:HW];
      half_q[HALF_AF_LO] <= DEF_VAL[HW-1:0];
      half_q[HALF_AF_HI] <= DEF_VAL[OFS_W-1:HW];
    end else if (ld_fire) begin
      half_q[lptr_q] <= ofs_din;
      lptr_q         <= ofs_half_e'(lptr_q + 2'd1);
    end
  end

  assign ae_ofs = {half_q[HALF_AE_HI], half_q[HALF_AE_LO]};
  assign af_ofs = {half_q[HALF_AF_HI], half_q[HALF_AF_LO]};
  assign we     = wr_fire;
  assign waddr  = wbin_q[AW-1:0];
  assign wgray  = wgray_q;

  // R6: no push accepted when the write-side count is already DEPTH
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!srst_n)
    wr_fire |-> ((wbin_q - rbin_s) != PW'(DEPTH)));
  // R12: write-side count never exceeds DEPTH
  p_fill_bound_r12: assert property (@(posedge clk) disable iff (!srst_n)
    (wbin_q - rbin_s) <= PW'(DEPTH));
  // R12: crossing pointer moves by at most one bit
  p_wgray_step_r12: assert property (@(posedge clk) disable iff (!srst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
  // R3: mode fixed outside reset
  p_wmode_hold_r3: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> $stable(mode_q));
endmodule

// File: rtl/xfifo_rd_ctl.sv
module xfifo_rd_ctl
  import xfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 9,
  parameter int unsigned OFS_W = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1,
  localparam int unsigned HW = OFS_W / 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             srst_n,
  input  logic             dual_pin,
  input  logic             rd_en_a_n,
  input  logic             rd_en_b_n,
  input  logic [PW-1:0]    wgray_s,
  input  logic [OFS_W-1:0] ae_ofs,
  input  logic [OFS_W-1:0] af_ofs,
  input  logic [DW-1:0]    rdata,
  output logic [AW-1:0]    raddr,
  output logic [PW-1:0]    rgray,
  output logic [DW-1:0]    q,
  output logic             empty_n,
  output logic             aempty_n
);
  fifo_mode_e    mode_q;
  ofs_half_e     bptr_q;
  logic [PW-1:0] rbin_q, rbin_d, rgray_q, wbin_s, cnt_d;
  logic [HW-1:0] bk_half;
  logic          rd_req, ld_sel, bk_fire, rd_fire, empty_n_d, aempty_n_d;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      mode_q <= MODE_DUAL_WE;
    else if (!srst_n) mode_q <= dual_pin ? MODE_DUAL_WE : MODE_PROG_FLAG;
  end

  always_comb begin
    rd_req     = !rd_en_a_n && !rd_en_b_n;
    ld_sel     = (mode_q == MODE_PROG_FLAG) && !dual_pin;
    bk_fire    = rd_req && ld_sel;
    rd_fire    = rd_req && !ld_sel && empty_n;
    rbin_d     = rbin_q + PW'(rd_fire);
    wbin_s     = PW'(gray2bin(32'(wgray_s)));
    cnt_d      = wbin_s - rbin_d;
    empty_n_d  = (cnt_d != '0);
    aempty_n_d = (OFS_W'(cnt_d) > ae_ofs);
    unique case (bptr_q)
      HALF_AE_LO: bk_half = ae_ofs[HW-1:0];
      HALF_AE_HI: bk_half = ae_ofs[OFS_W-1:HW];
      HALF_AF_LO: bk_half = af_ofs[HW-1:0];
      default:    bk_half = af_ofs[OFS_W-1:HW];
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      if (rd_fire) begin
        rbin_q  <= rbin_d;
        rgray_q <= PW'(bin2gray(32'(rbin_d)));
      end
      empty_n  <= empty_n_d;
      aempty_n <= aempty_n_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      q      <= '0;
      bptr_q <= HALF_AE_LO;
    end else if (bk_fire) begin
      q      <= DW'(bk_half);
      bptr_q <= ofs_half_e'(bptr_q + 2'd1);
    end else if (rd_fire) begin
      q      <= rdata;
    end
  end

  assign raddr = rbin_q[AW-1:0];
  assign rgray = rgray_q;

  // R5: no pop accepted when the read-side count is zero
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!srst_n)
    rd_fire |-> ((wbin_s - rbin_q) != '0));
  // R12: read-side count never exceeds DEPTH
  p_cnt_bound_r12: assert property (@(posedge clk) disable iff (!srst_n)
    (wbin_s - rbin_q) <= PW'(DEPTH));
  // R12: crossing pointer moves by at most one bit
  p_rgray_step_r12: assert property (@(posedge clk) disable iff (!srst_n)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
  // R3: mode fixed outside reset
  p_rmode_hold_r3: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> $stable(mode_q));
endmodule

// File: rtl/xfifo_pflag.sv
module xfifo_pflag #(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned DW      = 9,
  parameter int unsigned DEF_OFS = 7
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          dual_pin,
  input  logic          wr_en_n,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en_a_n,
  input  logic          rd_en_b_n,
  input  logic          out_en_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_data_drive,
  output logic          empty_n,
  output logic          almost_empty_n,
  output logic          full_n,
  output logic          almost_full_n
);
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned HW    = (PW + 1) / 2;
  localparam int unsigned OFS_W = 2 * HW;

  logic          wsrst_n, rsrst_n, we;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [DW-1:0] rdata, q;
  logic [OFS_W-1:0] ae_ofs, af_ofs;

  xfifo_rst_sync u_wrst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wsrst_n));
  xfifo_rst_sync u_rrst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rsrst_n));

  xfifo_sync #(.W(PW)) u_w2r (.clk(rd_clk), .srst_n(rsrst_n), .d(wgray), .q(wgray_s));
  xfifo_sync #(.W(PW)) u_r2w (.clk(wr_clk), .srst_n(wsrst_n), .d(rgray), .q(rgray_s));

  xfifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(rdata)
  );

  xfifo_wr_ctl #(.DEPTH(DEPTH), .OFS_W(OFS_W), .DEF_OFS(DEF_OFS)) u_wr (
    .clk(wr_clk), .arst_n(rst_n), .srst_n(wsrst_n), .dual_pin(dual_pin),
    .wr_en_n(wr_en_n), .ofs_din(wr_data[HW-1:0]), .rgray_s(rgray_s),
    .we(we), .waddr(waddr), .wgray(wgray), .full_n(full_n),
    .afull_n(almost_full_n), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  xfifo_rd_ctl #(.DEPTH(DEPTH), .DW(DW), .OFS_W(OFS_W)) u_rd (
    .clk(rd_clk), .arst_n(rst_n), .srst_n(rsrst_n), .dual_pin(dual_pin),
    .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n), .wgray_s(wgray_s),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .rdata(rdata), .raddr(raddr),
    .rgray(rgray), .q(q), .empty_n(empty_n), .aempty_n(almost_empty_n)
  );

  assign rd_data       = q;
  assign rd_data_drive = !out_en_n;
endmodule

// File: tb/xfifo_pflag_tb.sv
module xfifo_pflag_tb;
  localparam int DEPTH = 64;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  always #10 wr_clk = ~wr_clk;
  always #13 rd_clk = ~rd_clk;

  logic rst_n, dual_pin, wr_en_n, rd_en_a_n, rd_en_b_n, out_en_n;
  logic [8:0] wr_data, rd_data;
  logic rd_data_drive, empty_n, almost_empty_n, full_n, almost_full_n;

  xfifo_pflag u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .dual_pin(dual_pin),
    .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_a_n(rd_en_a_n),
    .rd_en_b_n(rd_en_b_n), .out_en_n(out_en_n), .rd_data(rd_data),
    .rd_data_drive(rd_data_drive), .empty_n(empty_n),
    .almost_empty_n(almost_empty_n), .full_n(full_n),
    .almost_full_n(almost_full_n)
  );

  int errs = 0, checks = 0;
  bit done = 1'b0;
  logic [8:0] sb[$];

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int exp_ae(input int cnt, input int ofs);
    return (cnt <= ofs) ? 0 : 1;
  endfunction

  function automatic int exp_af(input int cnt, input int ofs);
    return ((DEPTH - cnt) <= ofs) ? 0 : 1;
  endfunction

  task automatic settle();
    repeat (10) @(negedge rd_clk);
    repeat (10) @(negedge wr_clk);
  endtask

  task automatic do_reset(input logic pin);
    rst_n = 1'b0; dual_pin = pin; wr_en_n = 1'b1;
    rd_en_a_n = 1'b1; rd_en_b_n = 1'b1; wr_data = '0;
    sb.delete();
    repeat (4) @(negedge wr_clk);
    rst_n = 1'b1;
    settle();
  endtask

  task automatic push_words(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_data = 9'($urandom);
      wr_en_n = 1'b0;
      if (full_n && dual_pin) sb.push_back(wr_data);
    end
    @(negedge wr_clk);
    wr_en_n = 1'b1;
  endtask

  task automatic drain(input string req, output int nread);
    logic fire;
    logic [8:0] exp;
    nread = 0;
    while (sb.size() > 0) begin
      @(negedge rd_clk);
      rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
      fire = empty_n;
      @(negedge rd_clk);
      rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
      if (fire) begin
        exp = sb.pop_front();
        nread++;
        chk(req, int'(rd_data), int'(exp));
      end
    end
  endtask

  task automatic load_half(input int v);
    @(negedge wr_clk);
    wr_data = 9'(v); wr_en_n = 1'b0;
    @(negedge wr_clk);
    wr_en_n = 1'b1;
  endtask

  task automatic read_back(input string req, input int exp);
    @(negedge rd_clk);
    rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
    @(negedge rd_clk);
    rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
    chk(req, int'(rd_data), exp);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int nread, lat;
    int ks[6] = '{1, 7, 8, 56, 57, 64};
    void'($urandom(32'd2024));
    out_en_n = 1'b0;

    // R2 reset state in dual-qualifier mode
    do_reset(1'b1);
    chk("R2 empty_n", empty_n, 0);
    chk("R2 almost_empty_n", almost_empty_n, 0);
    chk("R2 full_n", full_n, 1);
    chk("R2 almost_full_n", almost_full_n, 1);
    chk("R2 rd_data", int'(rd_data), 0);

    // R11 drive enable
    chk("R11 drive on", rd_data_drive, 1);
    out_en_n = 1'b1; #1;
    chk("R11 drive off", rd_data_drive, 0);
    out_en_n = 1'b0; #1;
    chk("R11 drive back", rd_data_drive, 1);

    // R4 second qualifier low blocks writes; R3 pin low in dual mode is no load or read-back
    @(negedge wr_clk); dual_pin = 1'b0; wr_en_n = 1'b0; wr_data = 9'h1a5;
    repeat (3) @(negedge wr_clk);
    wr_en_n = 1'b1;
    rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
    repeat (3) @(negedge rd_clk);
    rd_en_a_n = 1'b1; rd_en_b_n = 1'b1; dual_pin = 1'b1;
    settle();
    chk("R4 blocked write keeps empty", empty_n, 0);
    chk("R3 no read-back in dual mode", int'(rd_data), 0);

    // R10 latency of empty_n after one push
    push_words(1);
    lat = 0;
    while (!empty_n && lat < 20) begin @(negedge rd_clk); lat++; end
    chk("R10 empty_n latency within 4", (lat <= 4) ? 1 : 0, 1);

    // R5 one enable high: no pop, data holds
    @(negedge rd_clk); rd_en_a_n = 1'b0; rd_en_b_n = 1'b1;
    repeat (3) @(negedge rd_clk);
    @(negedge rd_clk); rd_en_a_n = 1'b1; rd_en_b_n = 1'b0;
    repeat (3) @(negedge rd_clk);
    rd_en_b_n = 1'b1;
    settle();
    chk("R5 single enable no pop", empty_n, 1);
    chk("R5 rd_data held", int'(rd_data), 0);
    drain("R1 single word", nread);
    settle();
    chk("R5 empty after pop", empty_n, 0);

    // R6 R7 directed fill levels with default thresholds
    foreach (ks[k]) begin
      int eff;
      do_reset(1'b1);
      push_words((ks[k] == DEPTH) ? DEPTH + 3 : ks[k]);
      eff = (ks[k] > DEPTH) ? DEPTH : ks[k];
      settle();
      chk("R7 almost_empty_n level", almost_empty_n, exp_ae(eff, 7));
      chk("R7 almost_full_n level", almost_full_n, exp_af(eff, 7));
      chk("R6 full_n level", full_n, (eff == DEPTH) ? 0 : 1);
      chk("R1 empty_n level", empty_n, 1);
      drain("R1 R6 data", nread);
      chk("R6 pop count", nread, eff);
      settle();
      chk("R6 empty after drain", empty_n, 0);
    end

    // R1 R12 randomized traffic on both clocks
    do_reset(1'b1);
    fork
      begin
        for (int i = 0; i < 600; i++) begin
          @(negedge wr_clk);
          wr_data = 9'($urandom);
          wr_en_n = (($urandom % 10) < 6) ? 1'b0 : 1'b1;
          if (!wr_en_n && full_n) sb.push_back(wr_data);
        end
        @(negedge wr_clk); wr_en_n = 1'b1;
      end
      begin
        logic pend = 1'b0;
        for (int i = 0; i < 500; i++) begin
          @(negedge rd_clk);
          if (pend) chk("R1 R12 random data", int'(rd_data), int'(sb.pop_front()));
          rd_en_a_n = (($urandom % 4) == 0);
          rd_en_b_n = (($urandom % 5) == 0);
          pend = !rd_en_a_n && !rd_en_b_n && empty_n;
        end
        @(negedge rd_clk);
        if (pend) chk("R1 R12 random data", int'(rd_data), int'(sb.pop_front()));
        rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
      end
    join
    settle();
    drain("R1 R12 tail data", nread);
    settle();
    chk("R12 empty after random", empty_n, 0);

    // R2 R3 R8 R9 load mode
    do_reset(1'b0);
    read_back("R2 default ae lo", 7);
    read_back("R2 default ae hi", 0);
    read_back("R2 default af lo", 7);
    read_back("R2 default af hi", 0);
    load_half(9'h1f3);
    load_half(0);
    load_half(5);
    load_half(0);
    load_half(2);
    settle();
    chk("R8 loads not stored", empty_n, 0);
    read_back("R8 R9 ae lo after wrap", 2);
    read_back("R9 ae hi", 0);
    read_back("R9 af lo", 5);
    read_back("R9 af hi", 0);

    dual_pin = 1'b1;
    push_words(2);
    settle();
    chk("R7 count 2 vs ae 2", almost_empty_n, exp_ae(2, 2));
    push_words(1);
    settle();
    chk("R7 count 3 vs ae 2", almost_empty_n, exp_ae(3, 2));
    push_words(55);
    settle();
    chk("R7 count 58 vs af 5", almost_full_n, exp_af(58, 5));
    push_words(1);
    settle();
    chk("R7 count 59 vs af 5", almost_full_n, exp_af(59, 5));
    dual_pin = 1'b0;
    read_back("R9 read-back with data held", 2);
    dual_pin = 1'b1;
    drain("R9 R1 data after read-back", nread);
    chk("R9 no pop by read-back", nread, 59);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule